// File: doc/BRIEF.md
# Byte-Serial Wide Multiplier

This block multiplies a wide multiplicand by a multiplier that arrives one byte at a time, least significant byte first. For each accepted byte it forms the product of the whole multiplicand and that byte, adds it to a running accumulator, and emits the lowest byte of the sum. That byte is final. The accumulator then drops the emitted byte by shifting right by eight bits. The emitted bytes are also collected in a low-result shift register that fills from its top end.

Once the most significant multiplier byte has been processed, a load-high strobe copies the accumulator, which now holds the upper part of the product, into a high register and clears the accumulator for the next operation. Feeding a single multiplier byte of value 1 and then strobing load-high moves the multiplicand through the accumulator path. The low byte leaves on the byte output and the remaining bits land in the high register.

Top module: `byte_serial_mult`

## Requirements
- R1: After reset, `lo_valid_o`, `lo_byte_o`, `lo_reg_o` and `high_o` are all zero.
- R2: For the k-th accepted multiplier byte (k = 0 is the least significant), `lo_valid_o` is high in the following cycle and `lo_byte_o` equals bits [8k+7:8k] of the product.
- R3: A cycle with `mbyte_valid_i` low is idle. In the next cycle `lo_valid_o` is low and `lo_byte_o` keeps its value. Idle cycles between bytes do not change the final product.
- R4: Each emitted byte enters `lo_reg_o` at bits [MCAND_W-1:MCAND_W-8] one cycle after it appears on `lo_byte_o`, and the older contents move down by eight bits. After n bytes, the top 8n bits of `lo_reg_o` hold the low 8n bits of the product.
- R5: Strobing `load_high_i` after n multiplier bytes sets `high_o` to the product shifted right by 8n bits and clears the accumulator. The next multiplication therefore starts from zero.
- R6: When `load_high_i` and `mbyte_valid_i` are high in the same cycle, that byte is included in the value captured into `high_o`.
- R7: `high_o` changes only in the cycle after a `load_high_i` strobe.
- R8: A single multiplier byte of 1 followed by load-high gives `lo_byte_o` = multiplicand[7:0] and `high_o` = multiplicand >> 8.
- R9: The accumulator is MCAND_W+8 bits wide, and its top byte is zero between cycles even when both operands are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mcand_i | input | MCAND_W | Multiplicand, held stable for the whole operation |
| mbyte_i | input | 8 | Next multiplier byte |
| mbyte_valid_i | input | 1 | `mbyte_i` is accepted this cycle |
| load_high_i | input | 1 | Capture the accumulator into `high_o` and clear it |
| lo_byte_o | output | 8 | Last finished low product byte |
| lo_valid_o | output | 1 | `lo_byte_o` was produced in the previous cycle |
| lo_reg_o | output | MCAND_W | Low-result shift register |
| high_o | output | MCAND_W | High result register |

## Verification
The assertions assume that `mcand_i` does not change between the first multiplier byte and the load-high strobe. They also assume that no more than MCAND_W/8 bytes are fed per operation, because the no-overflow invariant on the accumulator top byte depends on this. The bench changes the multiplicand only after load-high, never feeds more than eight bytes per run, and includes an all-ones run that drives the partial sums to their largest values.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/bsm_pp_gen.sv
module bsm_pp_gen
  import bsm_pkg::*;
#(
  parameter int MCAND_W = 64,
  parameter int PP_W    = MCAND_W + BYTE_W
) (
  input  logic [MCAND_W-1:0] mcand_i,
  input  logic [BYTE_W-1:0]  byte_i,
  output logic [PP_W-1:0]    pp_o
);
  logic [PP_W-1:0] rows [BYTE_W];

  for (genvar g = 0; g < BYTE_W; g++) begin : g_row
    assign rows[g] = byte_i[g] ? (PP_W'(mcand_i) << g) : '0;
  end

  always_comb begin
    pp_o = '0;
    for (int i = 0; i < BYTE_W; i++) pp_o = pp_o + rows[i];
  end
endmodule

// File: rtl/bsm_accum.sv
module bsm_accum
  import bsm_pkg::*;
#(
  parameter int MCAND_W = 64,
  localparam int AW     = MCAND_W + BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      pp_i,
  input  logic               valid_i,
  input  logic               load_high_i,
  output logic [BYTE_W-1:0]  lo_byte_o,
  output logic               lo_valid_o,
  output logic [MCAND_W-1:0] high_o
);
  logic [AW-1:0] acc_q, sum, acc_nxt;

  assign sum     = acc_q + pp_i;
  assign acc_nxt = valid_i ? (sum >> BYTE_W) : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      lo_byte_o  <= '0;
      lo_valid_o <= 1'b0;
      high_o     <= '0;
    end else begin
      lo_valid_o <= valid_i;
      if (valid_i) lo_byte_o <= sum[BYTE_W-1:0];
      if (load_high_i) begin
        high_o <= acc_nxt[MCAND_W-1:0];  // includes a same-cycle byte
        acc_q  <= '0;
      end else begin
        acc_q  <= acc_nxt;
      end
    end
  end

  assert_acc_fits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q[AW-1 -: BYTE_W] == '0);
endmodule

// File: rtl/bsm_low_shreg.sv
module bsm_low_shreg
  import bsm_pkg::*;
#(
  parameter int LOW_BYTES = 8,
  localparam int LOW_W    = LOW_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [LOW_W-1:0]  lo_reg_o
);
  for (genvar g = 0; g < LOW_BYTES; g++) begin : g_byte
    logic [BYTE_W-1:0] src;
    if (g == LOW_BYTES - 1) begin : g_top
      assign src = byte_i;
    end else begin : g_mid
      assign src = lo_reg_o[(g+1)*BYTE_W +: BYTE_W];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lo_reg_o[g*BYTE_W +: BYTE_W] <= '0;
      else if (shift_i) lo_reg_o[g*BYTE_W +: BYTE_W] <= src;
    end
  end
endmodule

// File: rtl/byte_serial_mult.sv
module byte_serial_mult
  import bsm_pkg::*;
#(
  parameter int MCAND_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MCAND_W-1:0] mcand_i,
  input  logic [7:0]         mbyte_i,
  input  logic               mbyte_valid_i,
  input  logic               load_high_i,
  output logic [7:0]         lo_byte_o,
  output logic               lo_valid_o,
  output logic [MCAND_W-1:0] lo_reg_o,
  output logic [MCAND_W-1:0] high_o
);
  localparam int LOW_BYTES = MCAND_W / BYTE_W;
  localparam int AW        = MCAND_W + BYTE_W;

  logic [AW-1:0] pp;

  bsm_pp_gen #(.MCAND_W(MCAND_W)) u_pp (
    .mcand_i(mcand_i), .byte_i(mbyte_i), .pp_o(pp)
  );

  bsm_accum #(.MCAND_W(MCAND_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .pp_i(pp), .valid_i(mbyte_valid_i),
    .load_high_i(load_high_i), .lo_byte_o(lo_byte_o),
    .lo_valid_o(lo_valid_o), .high_o(high_o)
  );

  bsm_low_shreg #(.LOW_BYTES(LOW_BYTES)) u_low (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(lo_valid_o),
    .byte_i(lo_byte_o), .lo_reg_o(lo_reg_o)
  );

  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbyte_valid_i |=> lo_valid_o);
  assert_idle_no_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mbyte_valid_i |=> (!lo_valid_o && $stable(lo_byte_o)));
  assert_low_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_valid_o |=> lo_reg_o[MCAND_W-1 -: BYTE_W] == $past(lo_byte_o));
  assert_low_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_valid_o |=> $stable(lo_reg_o));
  assert_high_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_high_i |=> $stable(high_o));
endmodule

// File: tb/byte_serial_mult_test.sv
module byte_serial_mult_test;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [7:0]   mbyte = '0;
  logic         mvalid = 1'b0;
  logic         ld_high = 1'b0;
  logic [7:0]   lo_byte;
  logic         lo_valid;
  logic [W-1:0] lo_reg, high;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  byte_serial_mult #(.MCAND_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mcand_i(mcand), .mbyte_i(mbyte),
    .mbyte_valid_i(mvalid), .load_high_i(ld_high), .lo_byte_o(lo_byte),
    .lo_valid_o(lo_valid), .lo_reg_o(lo_reg), .high_o(high)
  );

  task automatic chk(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // feeds n bytes of mult; gap idle cycles after each; last byte with load if lw
  task automatic run_mult(input logic [W-1:0] m, input logic [W-1:0] mult,
                          input int n, input int gap, input bit lw);
    logic [2*W-1:0] p;
    logic [2*W-1:0] mask;
    p = {{W{1'b0}}, m} * {{W{1'b0}}, mult};
    mcand = m;
    for (int k = 0; k < n; k++) begin
      mvalid  = 1'b1;
      mbyte   = mult[8*k +: 8];
      ld_high = lw && (k == n - 1);
      @(negedge clk);
      chk("R2 valid", lo_valid, 1);
      chk("R2 byte", lo_byte, p[8*k +: 8]);
      mvalid  = 1'b0;
      ld_high = 1'b0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk("R3 idle valid", lo_valid, 0);
        chk("R3 idle byte", lo_byte, p[8*k +: 8]);
      end
    end
    if (!lw) begin
      ld_high = 1'b1;
      @(negedge clk);
      ld_high = 1'b0;
    end
    @(negedge clk);
    chk(lw ? "R6 high same cycle" : "R5 high", high, p >> (8*n));
    mask = (128'd1 << (8*n)) - 1;
    chk("R4 low reg", lo_reg >> (W - 8*n), p & mask);
  endtask

  task automatic t_reset;
    chk("R1 valid", lo_valid, 0);
    chk("R1 byte", lo_byte, 0);
    chk("R1 low", lo_reg, 0);
    chk("R1 high", high, 0);
  endtask

  task automatic t_random_full;
    for (int i = 0; i < 3; i++)
      run_mult({$urandom, $urandom}, {$urandom, $urandom}, 8, 0, 1'b0);
  endtask

  task automatic t_gaps;  // R3
    run_mult({$urandom, $urandom}, {$urandom, $urandom}, 8, 2, 1'b0);
  endtask

  task automatic t_short;  // R5 with fewer bytes
    run_mult({$urandom, $urandom}, {40'd0, 24'($urandom)}, 3, 0, 1'b0);
  endtask

  task automatic t_load_last;  // R6
    run_mult({$urandom, $urandom}, {$urandom, $urandom}, 8, 0, 1'b1);
  endtask

  task automatic t_hold;  // R7
    logic [W-1:0] h;
    h = high;
    mcand = 64'h0123_4567_89ab_cdef;
    for (int k = 0; k < 4; k++) begin
      mvalid = 1'b1;
      mbyte  = 8'(k + 3);
      @(negedge clk);
      chk("R7 high held during bytes", high, h);
    end
    mvalid = 1'b0;
    @(negedge clk);
    chk("R7 high held idle", high, h);
    ld_high = 1'b1;  // flush accumulator
    @(negedge clk);
    ld_high = 1'b0;
  endtask

  task automatic t_mul_one;  // R8
    logic [W-1:0] m;
    m = {$urandom, $urandom};
    mcand = m;
    mvalid = 1'b1;
    mbyte = 8'd1;
    @(negedge clk);
    chk("R8 low byte", lo_byte, m[7:0]);
    mvalid = 1'b0;
    ld_high = 1'b1;
    @(negedge clk);
    ld_high = 1'b0;
    chk("R8 high", high, m >> 8);
  endtask

  task automatic t_max;  // R9
    run_mult({W{1'b1}}, {W{1'b1}}, 8, 0, 1'b0);
    chk("R9 max product high", high, {W{1'b1}} - 1);
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_random_full();
    t_gaps();
    t_short();
    t_load_last();
    t_hold();
    t_mul_one();
    t_max();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule